// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block turns a single pulse-width command into the two gate drives of one half-bridge leg: a high-side drive that follows a command of 1 and a low-side drive that follows a command of 0. Whenever the leg changes side, the outgoing switch is released first. The incoming switch is held off for a guard interval counted in whole system clock ticks. Because the interval is an integer number of clock periods, the clock period sets its granularity. The realised interval can therefore differ from the intended analog time by up to one fraction of a tick.

The guard length comes in on a port as a tick count, and a count of zero is treated as one tick. The count is captured once per off interval, so a value that moves while a switch is conducting, or while the interval is running, cannot stretch or cut short the interval in progress. A command that reverses before the interval expires is simply followed when it expires. A narrow command pulse can therefore vanish from the outputs, but the guard before the next turn-on is still kept. The asynchronous reset forces both drives low at once. The reset is released through a short synchroniser, and the first turn-on after release also waits out a full guard interval.

Top module: `halfbridge_deadband`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in the same clock cycle.
- R2: While one drive is 1 and `pwm_cmd` calls for the other side (1 means high side, 0 means low side), that drive is 0 after the next rising edge.
- R3: With the effective guard count D, after the edge that releases a drive both drives stay 0 for D cycles, and the drive selected by `pwm_cmd` becomes 1 on the D-th rising edge after the release edge.
- R4: A `dead_ticks` value of 0 gives D = 1, so both drives are 0 for at least one cycle at every side change.
- R5: D is taken from `dead_ticks` as present at the release edge (or at the first active edge after reset). Values on `dead_ticks` at any other time, while a drive is on or while the guard is counting, have no effect.
- R6: When the guard expires, the side named by `pwm_cmd` at that moment is turned on. If the command returned to its former side during the guard, the other drive never rises, and the former side comes back only after the full D cycles.
- R7: `rst_n` low drives both outputs to 0 without waiting for a clock. After `rst_n` rises, the first drive turns on at rising edge D+3 (two synchroniser edges, one capture edge, D count edges), with D taken at edge 3.
- R8: In steady state `gate_hi` equals 1 when `pwm_cmd` is 1 and `gate_lo` equals 1 when `pwm_cmd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd | input | 1 | Side request: 1 for high side, 0 for low side |
| dead_ticks | input | DT_W (8) | Guard length in clock ticks; 0 is treated as 1 |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
On the edge that releases one switch, the block also captures the guard length for the coming off interval, so a release and a guard-length change can land in the same cycle. The bench drives a new `dead_ticks` value together with the command flip at one negative edge. On the very next cycle, with the guard already running, it drives yet another value. It then judges which value governed by the exact edge on which the incoming drive rises. A second collision, the command reversing in the cycle the guard expires, is provoked with a command pulse narrower than the guard. It is judged by the low drive never rising and the high drive returning on the counted edge.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Leg control states; a drive is on only in LEG_HI or LEG_LO.
  typedef enum logic [1:0] {
    LEG_ARM = 2'd0,  // both off, guard length not yet captured
    LEG_GAP = 2'd1,  // both off, guard counting
    LEG_HI  = 2'd2,  // high-side switch conducting
    LEG_LO  = 2'd3   // low-side switch conducting
  } leg_state_t;

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 1'b0;
        else         stage_q <= 1'b1;
      end
      assign srst_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign srst_n = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [DT_W-1:0] gap_i,
  output logic            expired_o
);

  localparam logic [DT_W-1:0] ONE_TICK = DT_W'(1);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_d;
  logic [DT_W-1:0] gap_eff;
  logic            cnt_en;

  // Next-state: a zero request is raised to one tick; load holds D-1
  // so that the turn-on lands on the D-th edge after the load edge.
  always_comb begin
    gap_eff = (gap_i == '0) ? ONE_TICK : gap_i;
    cnt_en  = load_i | (cnt_q != '0);
    cnt_d   = cnt_q;
    if (load_i)             cnt_d = gap_eff - ONE_TICK;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE_TICK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/hb_leg_fsm.sv
module hb_leg_fsm
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic expired_i,
  output logic load_o,
  output logic hi_o,
  output logic lo_o
);

  leg_state_t st_q;
  leg_state_t st_d;

  // Next-state: any release goes through LEG_GAP and captures the guard.
  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    unique case (st_q)
      LEG_ARM: begin
        load_o = 1'b1;
        st_d   = LEG_GAP;
      end
      LEG_GAP: begin
        if (expired_i) st_d = cmd_i ? LEG_HI : LEG_LO;
      end
      LEG_HI: begin
        if (!cmd_i) begin
          load_o = 1'b1;
          st_d   = LEG_GAP;
        end
      end
      LEG_LO: begin
        if (cmd_i) begin
          load_o = 1'b1;
          st_d   = LEG_GAP;
        end
      end
      default: st_d = LEG_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LEG_ARM;
    else        st_q <= st_d;
  end

  assign hi_o = (st_q == LEG_HI);
  assign lo_o = (st_q == LEG_LO);

endmodule

// File: rtl/halfbridge_deadband.sv
module halfbridge_deadband #(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_cmd,
  input  logic [DT_W-1:0] dead_ticks,
  output logic            gate_hi,
  output logic            gate_lo
);

  logic core_rst_n;
  logic guard_load;
  logic guard_done;

  hb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  hb_gap_timer #(.DT_W(DT_W)) u_timer (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load_i    (guard_load),
    .gap_i     (dead_ticks),
    .expired_o (guard_done)
  );

  hb_leg_fsm u_fsm (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cmd_i     (pwm_cmd),
    .expired_i (guard_done),
    .load_o    (guard_load),
    .hi_o      (gate_hi),
    .lo_o      (gate_lo)
  );

endmodule

// File: rtl/hb_leg_chk.sv
module hb_leg_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd,
  input logic hi,
  input logic lo
);

  a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));

  a_r2_hi_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && !cmd) |=> !hi);

  a_r2_lo_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && cmd) |=> !lo);

  a_r3_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> !$past(lo));

  a_r3_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo) |-> !$past(hi));

  a_r7_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!hi && !lo));

endmodule

bind halfbridge_deadband hb_leg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cmd   (pwm_cmd),
  .hi    (gate_hi),
  .lo    (gate_lo)
);

// File: tb/halfbridge_deadband_tb.sv
`timescale 1ns/1ps
module halfbridge_deadband_tb;

  localparam int DT_W = 8;

  typedef struct packed {
    logic            cmd;
    logic [DT_W-1:0] gap;
    logic [7:0]      wait_n;
    logic            exp_hi;
    logic            exp_lo;
    logic [3:0]      req;
  } vec_t;

  // Each row: drive cmd/gap at a negative edge, wait wait_n cycles, check.
  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 4'd8}, // R8 steady low side
    '{1'b1, 8'd3, 8'd1, 1'b0, 1'b0, 4'd2}, // R2 release next edge
    '{1'b1, 8'd3, 8'd2, 1'b0, 1'b0, 4'd3}, // R3 still in guard
    '{1'b1, 8'd3, 8'd1, 1'b1, 1'b0, 4'd3}, // R3 on at edge 3
    '{1'b1, 8'd3, 8'd5, 1'b1, 1'b0, 4'd8}, // R8 steady high side
    '{1'b0, 8'd5, 8'd1, 1'b0, 1'b0, 4'd2}, // R2 release, new gap 5
    '{1'b0, 8'd5, 8'd4, 1'b0, 1'b0, 4'd5}, // R5 new gap in force
    '{1'b0, 8'd5, 8'd1, 1'b0, 1'b1, 4'd5}, // R5 on at edge 5
    '{1'b0, 8'd0, 8'd3, 1'b0, 1'b1, 4'd5}, // R5 gap change while on
    '{1'b1, 8'd0, 8'd1, 1'b0, 1'b0, 4'd4}, // R4 zero gap still 1 tick
    '{1'b1, 8'd0, 8'd1, 1'b1, 1'b0, 4'd4}, // R4 on at edge 1
    '{1'b0, 8'd0, 8'd1, 1'b0, 1'b0, 4'd4}, // R4
    '{1'b0, 8'd0, 8'd1, 1'b0, 1'b1, 4'd4}, // R4
    '{1'b0, 8'd6, 8'd3, 1'b0, 1'b1, 4'd5}, // R5 gap 6 while on, no effect
    '{1'b1, 8'd2, 8'd2, 1'b0, 1'b0, 4'd5}, // R5 gap 2 with flip
    '{1'b1, 8'd7, 8'd1, 1'b1, 1'b0, 4'd5}, // R5 gap 7 in guard ignored
    '{1'b1, 8'd4, 8'd3, 1'b1, 1'b0, 4'd8}, // R8
    '{1'b0, 8'd4, 8'd2, 1'b0, 1'b0, 4'd6}, // R6 narrow low request
    '{1'b1, 8'd4, 8'd1, 1'b0, 1'b0, 4'd6}, // R6 request withdrawn
    '{1'b1, 8'd4, 8'd1, 1'b0, 1'b0, 4'd6}, // R6 low never rises
    '{1'b1, 8'd4, 8'd1, 1'b1, 1'b0, 4'd6}  // R6 high back after D=4
  };

  logic            clk;
  logic            rst_n;
  logic            pwm_cmd;
  logic [DT_W-1:0] dead_ticks;
  logic            gate_hi;
  logic            gate_lo;

  int total;
  int bad;
  int overlap_cnt;
  int nogap_cnt;
  logic done;
  logic prev_hi;
  logic prev_lo;

  halfbridge_deadband #(.DT_W(DT_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_cmd    (pwm_cmd),
    .dead_ticks (dead_ticks),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Continuous monitor for R1 and the one-cycle minimum of R3/R4.
  initial begin
    overlap_cnt = 0;
    nogap_cnt   = 0;
    prev_hi     = 1'b0;
    prev_lo     = 1'b0;
    forever begin
      @(negedge clk);
      if (gate_hi && gate_lo) overlap_cnt++;
      if ((gate_hi && prev_lo) || (gate_lo && prev_hi)) nogap_cnt++;
      prev_hi = gate_hi;
      prev_lo = gate_lo;
    end
  end

  task automatic chk(input string req, input logic got_hi, input logic got_lo,
                     input logic exp_hi, input logic exp_lo);
    total++;
    if (got_hi !== exp_hi || got_lo !== exp_lo) begin
      bad++;
      $display("FAIL %s: hi/lo = %b%b, expected %b%b at %0t",
               req, got_hi, got_lo, exp_hi, exp_lo, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run = hung, expected = finished");
      finish_run();
    end
  end

  initial begin
    total      = 0;
    bad        = 0;
    rst_n      = 1'b0;
    pwm_cmd    = 1'b0;
    dead_ticks = 8'd3;

    // R7: outputs low while in reset.
    cycles(3);
    chk("R7 in reset", gate_hi, gate_lo, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R7: D=3, first turn-on at edge 6 after release.
    cycles(5);
    chk("R7 before first turn-on", gate_hi, gate_lo, 1'b0, 1'b0);
    cycles(1);
    chk("R7 first turn-on", gate_hi, gate_lo, 1'b0, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      pwm_cmd    = VECS[i].cmd;
      dead_ticks = VECS[i].gap;
      cycles(int'(VECS[i].wait_n));
      tag = $sformatf("R%0d row %0d", VECS[i].req, i);
      chk(tag, gate_hi, gate_lo, VECS[i].exp_hi, VECS[i].exp_lo);
    end

    // R7: asynchronous reset clears a conducting drive without a clock.
    rst_n = 1'b0;
    #1;
    chk("R7 async clear", gate_hi, gate_lo, 1'b0, 1'b0);
    pwm_cmd    = 1'b1;
    dead_ticks = 8'd0;
    cycles(2);
    rst_n = 1'b1;
    // R7 with R4: D=1, first turn-on at edge 4 after release.
    cycles(3);
    chk("R7 restart guard", gate_hi, gate_lo, 1'b0, 1'b0);
    cycles(1);
    chk("R7 restart turn-on", gate_hi, gate_lo, 1'b1, 1'b0);

    cycles(2);
    total++;
    if (overlap_cnt != 0) begin
      bad++;
      $display("FAIL R1: overlap cycles = %0d, expected 0", overlap_cnt);
    end
    total++;
    if (nogap_cnt != 0) begin
      bad++;
      $display("FAIL R3: direct side changes = %0d, expected 0", nogap_cnt);
    end

    done = 1'b1;
    finish_run();
  end

endmodule